// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Forwarding

This block gathers 32 level-sensitive interrupt sources and condenses them into one combined request toward a primary controller. It holds an enable mask and a software request latch. The combined request is raised while any enabled source is active. Each source drives its line straight to the block; there is no edge capture and no priority logic.

Some sources can skip the combined line. A contiguous band of sources, bits 21 to 30 by default, can each be forwarded on a dedicated output line. Each forwarded line follows its source level without a clock. A separate enable register, changed through set and clear words, decides which sources in the band are forwarded.

Software reaches the block over a small word-indexed register bus with select, write strobe, word index, write data and read data. Every register change uses a set word or a clear word, so no read-modify-write is needed.

Top module: `sic_top`

## Requirements
- R1: While reset is asserted at a clock edge, the enable mask, the forwarding enables and the software latch all become zero. After reset the combined line and all forwarded lines are low.
- R2: Word index 1 reads the raw level. The raw level is the source inputs, with the software latch ORed into bit 0.
- R3: A write to word index 2 ORs the write data into the enable mask. A read of word index 2 returns the mask.
- R4: A write to word index 3 clears every mask bit where the write data holds a one.
- R5: Word index 0 reads the masked status, which is the raw level ANDed with the mask.
- R6: Output line 31 is high exactly when the masked status is nonzero.
- R7: A write to word index 8 sets forwarding enables only for bits 21 to 30 (data bits under 0x7FE00000). Other data bits are ignored. A read of word index 8 returns the forwarding enables.
- R8: A write to word index 9 clears every forwarding enable where the write data holds a one.
- R9: Output lines 0 to 30 equal the raw level ANDed with their forwarding enable. They follow input changes in the same cycle, without a clock, and lines that are not enabled stay low.
- R10: A write of nonzero data to word index 4 sets the software latch. A write of nonzero data to word index 5 clears it. A write of zero to either word does nothing. A read of word index 4 returns raw bit 0 in bit 0 and zero in all other bits.
- R11: Reads of any word index other than 0, 1, 2, 4 and 8 return zero. Writes to any word index other than 2, 3, 4, 5, 8 and 9 change nothing.
- R12: A write takes effect on the clock edge that ends the cycle in which select and write strobe are high. Outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe; when low, a selected cycle is a read |
| bus_widx | input | 10 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when not selected |
| src_in | input | 32 | Level-sensitive interrupt sources |
| line_out | output | 32 | Bits 0-30 are forwarded lines; bit 31 is the combined request |

## Verification
The hardest case to reach is the interplay of three paths that share bit 0 and the forwarding band. The software latch, the external source and the forwarding enable must be set in several combinations. The combined line must then be seen to switch while the forwarded lines keep their own values. The stimulus table builds that state step by step: it enables a band through an all-ones write, retires part of it, raises the latch with a multi-bit value, and then tries to clear the latch with zero. Directed steps change a forwarded source between clock edges, and sample a mask write both just before and just after its edge.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int IDX_W = 10;

  // register word indices
  localparam logic [IDX_W-1:0] W_STATUS   = 10'd0;
  localparam logic [IDX_W-1:0] W_RAW      = 10'd1;
  localparam logic [IDX_W-1:0] W_MASK_SET = 10'd2;
  localparam logic [IDX_W-1:0] W_MASK_CLR = 10'd3;
  localparam logic [IDX_W-1:0] W_SOFT_SET = 10'd4;
  localparam logic [IDX_W-1:0] W_SOFT_CLR = 10'd5;
  localparam logic [IDX_W-1:0] W_FWD_SET  = 10'd8;
  localparam logic [IDX_W-1:0] W_FWD_CLR  = 10'd9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int FWD_LO = 21,
  parameter int FWD_HI = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] widx,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] fwd_q,
  output logic             soft_q
);
  logic any_data;
  assign any_data = |wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_stb && widx == W_MASK_SET) begin
      mask_q <= mask_q | wdata;
    end else if (wr_stb && widx == W_MASK_CLR) begin
      mask_q <= mask_q & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
    end else if (wr_stb && widx == W_SOFT_SET && any_data) begin
      soft_q <= 1'b1;
    end else if (wr_stb && widx == W_SOFT_CLR && any_data) begin
      soft_q <= 1'b0;
    end
  end

  // forwarding enables: storage only inside the band
  for (genvar i = 0; i < N_SRC; i++) begin : g_fwd
    if (i >= FWD_LO && i <= FWD_HI) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) begin
          fwd_q[i] <= 1'b0;
        end else if (wr_stb && widx == W_FWD_SET && wdata[i]) begin
          fwd_q[i] <= 1'b1;
        end else if (wr_stb && widx == W_FWD_CLR && wdata[i]) begin
          fwd_q[i] <= 1'b0;
        end
      end
    end else begin : g_tied
      assign fwd_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sic_rdmux.sv
module sic_rdmux
  import sic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] widx,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0] fwd_q,
  output logic [N_SRC-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      case (widx)
        W_STATUS:   rdata = raw & mask_q;
        W_RAW:      rdata = raw;
        W_MASK_SET: rdata = mask_q;
        W_SOFT_SET: rdata = {{(N_SRC-1){1'b0}}, raw[0]};
        W_FWD_SET:  rdata = fwd_q;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sic_lines.sv
module sic_lines #(
  parameter int N_SRC = 32
) (
  input  logic             [N_SRC-1:0] raw,
  input  logic             [N_SRC-1:0] mask_q,
  input  logic             [N_SRC-2:0] fwd_en,
  output logic             [N_SRC-1:0] lines
);
  assign lines[N_SRC-1]   = |(raw & mask_q);
  assign lines[N_SRC-2:0] = raw[N_SRC-2:0] & fwd_en;
endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int FWD_LO = 21,
  parameter int FWD_HI = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_widx,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] line_out
);
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] fwd_q;
  logic             soft_q;
  logic [N_SRC-1:0] raw;
  logic             wr_stb;
  logic             rd_stb;

  assign wr_stb = bus_sel & bus_wr;
  assign rd_stb = bus_sel & ~bus_wr;
  assign raw    = src_in | {{(N_SRC-1){1'b0}}, soft_q};

  sic_regs #(.N_SRC(N_SRC), .FWD_LO(FWD_LO), .FWD_HI(FWD_HI)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .widx   (bus_widx),
    .wdata  (bus_wdata),
    .mask_q (mask_q),
    .fwd_q  (fwd_q),
    .soft_q (soft_q)
  );

  sic_rdmux #(.N_SRC(N_SRC)) u_rdmux (
    .rd_stb (rd_stb),
    .widx   (bus_widx),
    .raw    (raw),
    .mask_q (mask_q),
    .fwd_q  (fwd_q),
    .rdata  (bus_rdata)
  );

  sic_lines #(.N_SRC(N_SRC)) u_lines (
    .raw    (raw),
    .mask_q (mask_q),
    .fwd_en (fwd_q[N_SRC-2:0]),
    .lines  (line_out)
  );
endmodule

// File: rtl/sic_checker.sv
module sic_checker
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int FWD_LO = 21,
  parameter int FWD_HI = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_widx,
  input logic [N_SRC-1:0] bus_wdata,
  input logic [N_SRC-1:0] src_in,
  input logic [N_SRC-1:0] line_out,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] fwd_q,
  input logic             soft_q
);
  localparam int FWD_CNT = FWD_HI - FWD_LO + 1;
  localparam logic [N_SRC-1:0] BAND =
    {{(N_SRC-FWD_CNT){1'b0}}, {FWD_CNT{1'b1}}} << FWD_LO;

  logic wr, known;
  assign wr = bus_sel && bus_wr;
  assign known = (bus_widx == W_MASK_SET) || (bus_widx == W_MASK_CLR) ||
                 (bus_widx == W_SOFT_SET) || (bus_widx == W_SOFT_CLR) ||
                 (bus_widx == W_FWD_SET)  || (bus_widx == W_FWD_CLR);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && fwd_q == '0 && !soft_q));

  p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_widx == W_MASK_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_widx == W_MASK_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_combined_r6: assert property (@(posedge clk) disable iff (rst)
    line_out[N_SRC-1] == ((|(src_in & mask_q)) || (soft_q && mask_q[0])));

  p_fwd_set_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_widx == W_FWD_SET) |=>
      ((fwd_q & BAND & $past(bus_wdata)) == (BAND & $past(bus_wdata))));

  p_fwd_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_widx == W_FWD_CLR) |=> ((fwd_q & $past(bus_wdata)) == '0));

  p_line_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (line_out[N_SRC-2:0] & ~fwd_q[N_SRC-2:0]) == '0);

  p_soft_set_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_widx == W_SOFT_SET && bus_wdata != '0) |=> soft_q);

  p_soft_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && (bus_widx == W_SOFT_SET || bus_widx == W_SOFT_CLR) && bus_wdata == '0)
      |=> $stable(soft_q));

  p_undef_write_r11: assert property (@(posedge clk) disable iff (rst)
    (wr && !known) |=> ($stable(mask_q) && $stable(fwd_q) && $stable(soft_q)));
endmodule

bind sic_top sic_checker #(.N_SRC(N_SRC), .FWD_LO(FWD_LO), .FWD_HI(FWD_HI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_widx  (bus_widx),
  .bus_wdata (bus_wdata),
  .src_in    (src_in),
  .line_out  (line_out),
  .mask_q    (mask_q),
  .fwd_q     (fwd_q),
  .soft_q    (soft_q)
);

// File: tb/sic_top_test.sv
module sic_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic [31:0] line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sic_top uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .line_out(line_out)
  );

  // op codes: 0 drive inputs, 1 write, 2 read-and-compare, 3 compare lines
  localparam int NV = 44;
  localparam logic [79:0] TBL [0:NV-1] = '{
    {2'd0, 10'd0,  32'h000000F0, 32'h0,        4'd2},  // R2
    {2'd2, 10'd1,  32'h0,        32'h000000F0, 4'd2},  // R2
    {2'd2, 10'd0,  32'h0,        32'h0,        4'd5},  // R5
    {2'd3, 10'd0,  32'h0,        32'h0,        4'd6},  // R6
    {2'd1, 10'd2,  32'h00000030, 32'h0,        4'd3},  // R3
    {2'd2, 10'd2,  32'h0,        32'h00000030, 4'd3},  // R3
    {2'd2, 10'd0,  32'h0,        32'h00000030, 4'd5},  // R5
    {2'd3, 10'd0,  32'h0,        32'h80000000, 4'd6},  // R6
    {2'd1, 10'd3,  32'h00000010, 32'h0,        4'd4},  // R4
    {2'd2, 10'd2,  32'h0,        32'h00000020, 4'd4},  // R4
    {2'd1, 10'd3,  32'h00000020, 32'h0,        4'd4},  // R4
    {2'd2, 10'd0,  32'h0,        32'h0,        4'd5},  // R5
    {2'd3, 10'd0,  32'h0,        32'h0,        4'd6},  // R6
    {2'd1, 10'd8,  32'hFFFFFFFF, 32'h0,        4'd7},  // R7
    {2'd2, 10'd8,  32'h0,        32'h7FE00000, 4'd7},  // R7
    {2'd0, 10'd0,  32'h40200010, 32'h0,        4'd9},  // R9
    {2'd3, 10'd0,  32'h0,        32'h40200000, 4'd9},  // R9
    {2'd1, 10'd9,  32'h40000000, 32'h0,        4'd8},  // R8
    {2'd2, 10'd8,  32'h0,        32'h3FE00000, 4'd8},  // R8
    {2'd3, 10'd0,  32'h0,        32'h00200000, 4'd9},  // R9
    {2'd2, 10'd4,  32'h0,        32'h0,        4'd10}, // R10
    {2'd1, 10'd4,  32'h0,        32'h0,        4'd10}, // R10
    {2'd2, 10'd4,  32'h0,        32'h0,        4'd10}, // R10
    {2'd1, 10'd4,  32'h00000005, 32'h0,        4'd10}, // R10
    {2'd2, 10'd4,  32'h0,        32'h00000001, 4'd10}, // R10
    {2'd2, 10'd1,  32'h0,        32'h40200011, 4'd2},  // R2
    {2'd1, 10'd2,  32'h00000001, 32'h0,        4'd3},  // R3
    {2'd3, 10'd0,  32'h0,        32'h80200000, 4'd6},  // R6
    {2'd1, 10'd5,  32'h0,        32'h0,        4'd10}, // R10
    {2'd2, 10'd4,  32'h0,        32'h00000001, 4'd10}, // R10
    {2'd1, 10'd5,  32'h00000100, 32'h0,        4'd10}, // R10
    {2'd2, 10'd4,  32'h0,        32'h0,        4'd10}, // R10
    {2'd3, 10'd0,  32'h0,        32'h00200000, 4'd6},  // R6
    {2'd1, 10'd6,  32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    {2'd1, 10'd7,  32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    {2'd1, 10'd10, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    {2'd2, 10'd2,  32'h0,        32'h00000001, 4'd11}, // R11
    {2'd2, 10'd8,  32'h0,        32'h3FE00000, 4'd11}, // R11
    {2'd2, 10'd6,  32'h0,        32'h0,        4'd11}, // R11
    {2'd2, 10'd3,  32'h0,        32'h0,        4'd11}, // R11
    {2'd2, 10'd9,  32'h0,        32'h0,        4'd11}, // R11
    {2'd2, 10'd5,  32'h0,        32'h0,        4'd11}, // R11
    {2'd2, 10'd1023, 32'h0,      32'h0,        4'd11}, // R11
    {2'd2, 10'd4,  32'h0,        32'h0,        4'd11}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input string req, input logic [9:0] idx, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = idx;
    #1;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_lines(input string req, input logic [31:0] exp);
    @(negedge clk);
    #1;
    check(req, line_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    do_read("R1", 10'd2, 32'h0);
    do_read("R1", 10'd8, 32'h0);
    do_read("R1", 10'd4, 32'h0);
    do_lines("R1", 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [9:0]  ix;
      logic [31:0] dt, ex;
      string       rq;
      op = TBL[i][79:78]; ix = TBL[i][77:68];
      dt = TBL[i][67:36]; ex = TBL[i][35:4];
      rq = $sformatf("R%0d", TBL[i][3:0]);
      case (op)
        2'd0: begin @(negedge clk); src_in = dt; end
        2'd1: do_write(ix, dt);
        2'd2: do_read(rq, ix, ex);
        default: do_lines(rq, ex);
      endcase
    end

    // R9: forwarded line follows its source without a clock edge
    @(negedge clk);
    src_in = 32'h42200010;
    #1;
    check("R9", line_out, 32'h02200000);

    // R12: mask write is visible only after its edge
    @(negedge clk);
    src_in = 32'h42200012;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = 10'd3; bus_wdata = 32'h00000001;
    @(negedge clk);
    bus_widx = 10'd2; bus_wdata = 32'h00000002;
    #1;
    check("R12", {31'h0, line_out[31]}, 32'h0);
    @(posedge clk);
    #1;
    check("R12", {31'h0, line_out[31]}, 32'h1);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    src_in = 32'h42200010;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_read("R1", 10'd2, 32'h0);
    do_read("R1", 10'd8, 32'h0);
    do_read("R1", 10'd0, 32'h0);
    do_lines("R1", 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule